// File: doc/BRIEF.md
# Link Loopback and Transmit-Enable Controller

This block sits between the framer of a serial fronthaul link and its transceiver. It routes parallel words with per-byte K-character flags among normal traffic and three forward loopback points, where the local transmit stream returns to the local receive path. It also drives a reverse loopback, where chosen regions of each received frame are sent back out on the transmit side. A two-bit forward field picks the loopback point. A four-bit echo mask picks the frame regions that are echoed.

The block also decides when the node may transmit. A node in slave mode keeps its transmitter idle until its receive side has locked to comma characters at the frame-start position. A master transmits at once. A force input lets a slave start before lock, so that a slave wired to itself can reach frame synchronisation with no partner node.

The receive path tells the framer through a valid flag when the loopback configuration has just changed. A small detector counts aligned commas to declare lock and missing commas to drop it.

Top module: `link_loop_ctrl`

## Requirements
- R1: With `lb_fwd_i` = 2'b00, `fr_rx_data_o`/`fr_rx_k_o` equal `xcv_rx_data_i`/`xcv_rx_k_i` one clock later, and `xcv_loop_o` is 0.
- R2: With `lb_fwd_i` = 2'b01, `xcv_loop_o` is 1 so that the transceiver loops serially, and the receive outputs still follow `xcv_rx_data_i` one clock later.
- R3: With `lb_fwd_i` = 2'b11, `fr_rx_data_o` equals `fr_tx_data_i` one clock later, bypassing the transmit stitch register.
- R4: With `lb_fwd_i` = 2'b10, `fr_rx_data_o` equals the word that was on `xcv_tx_data_o` one clock earlier, which is two clocks after `fr_tx_data_i`. Echo merging and transmit gating are included.
- R5: With the echo mask at zero and transmit enabled, `xcv_tx_data_o`/`xcv_tx_k_o` equal `fr_tx_data_i`/`fr_tx_k_i` one clock later.
- R6: A transmit word index is 0 in the first cycle after reset, advances by one each cycle and wraps after 15. Index 0 is region 0, 1 to 3 region 1, 4 to 7 region 2, and 8 to 15 region 3. When bit r of `lb_echo_i` is set for the current region, the transmitted word and its K flags come from `xcv_rx_data_i`/`xcv_rx_k_i` instead of the local input.
- R7: `fr_rx_valid_o` is 0 in the cycle after any change of `lb_fwd_i` or `lb_echo_i`, and is 1 otherwise once out of reset.
- R8: When `tx_enable_o` is 0, `xcv_tx_data_o` and `xcv_tx_k_o` are all zero one clock later. A slave with no force and no lock has `tx_enable_o` = 0.
- R9: A comma is a word whose low byte is 8'hBC with K flag bit 0 set. While unlocked, a comma away from the frame-start position restarts the frame position and counts as the first aligned comma. `rx_locked_o` rises after 4 consecutive commas at the frame start of the selected receive stream.
- R10: While locked, `rx_locked_o` falls after 4 consecutive frame starts without a comma. A comma at a frame start clears the miss count.
- R11: During reset, all data outputs, `fr_rx_valid_o` and `rx_locked_o` are 0.
- R12: `tx_enable_o` is 1 whenever `is_master_i` or `tx_force_i` is 1, whatever the lock state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| is_master_i | input | 1 | Node runs as link master |
| tx_force_i | input | 1 | Allow slave transmission before lock |
| lb_fwd_i | input | 2 | Forward loopback select |
| lb_echo_i | input | 4 | Reverse loopback region mask |
| fr_tx_data_i | input | 32 | Transmit word from framer |
| fr_tx_k_i | input | 4 | Transmit K flags from framer |
| xcv_rx_data_i | input | 32 | Received word from transceiver |
| xcv_rx_k_i | input | 4 | Received K flags from transceiver |
| xcv_tx_data_o | output | 32 | Transmit word to transceiver |
| xcv_tx_k_o | output | 4 | Transmit K flags to transceiver |
| xcv_loop_o | output | 1 | Request serial loopback inside transceiver |
| fr_rx_data_o | output | 32 | Receive word to framer |
| fr_rx_k_o | output | 4 | Receive K flags to framer |
| fr_rx_valid_o | output | 1 | Receive word valid |
| rx_locked_o | output | 1 | Receive comma lock |
| tx_enable_o | output | 1 | Transmission permitted |

## Verification
Reverse echo and the stitched parallel loop can act on the same word in the same cycle. A word merged from the received stream and the local stream is registered for the transceiver and, in that same register, is routed back into the receive path. The bench provokes this by setting the forward field to 2'b10 and a partial echo mask in one step, then walking a full frame. It judges each transmitted word against its own region map, and judges each received word against the merged word it predicted one cycle earlier. Writing both fields at once also brings the valid dip into the same cycle.

// File: rtl/llc_pkg.sv
package llc_pkg;

  typedef enum logic [1:0] {
    LB_NONE       = 2'b00,
    LB_SERIAL     = 2'b01,
    LB_PAR_STITCH = 2'b10,
    LB_PAR_DIRECT = 2'b11
  } lb_mode_e;

  localparam int N_REGION = 4;
  localparam logic [7:0] COMMA_BYTE = 8'hBC;

  // region of a word inside a basic frame of fw words
  function automatic logic [1:0] region_of(input int idx, input int fw);
    if (idx == 0)           return 2'd0;
    else if (idx < fw / 4)  return 2'd1;
    else if (idx < fw / 2)  return 2'd2;
    else                    return 2'd3;
  endfunction

  function automatic logic is_comma(input logic [7:0] low_byte, input logic k0);
    return k0 && (low_byte == COMMA_BYTE);
  endfunction

endpackage

// File: rtl/llc_tx_path.sv
module llc_tx_path
  import llc_pkg::*;
#(
  parameter int W  = 32,
  parameter int KW = 4,
  parameter int FW = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [W-1:0]        loc_data_i,
  input  logic [KW-1:0]       loc_k_i,
  input  logic [W-1:0]        echo_data_i,
  input  logic [KW-1:0]       echo_k_i,
  input  logic [N_REGION-1:0] echo_mask_i,
  input  logic                tx_en_i,
  output logic [W-1:0]        st_data_o,
  output logic [KW-1:0]       st_k_o,
  output logic                echo_sel_o
);
  localparam int IW = $clog2(FW);
  localparam int LW = W / KW;

  logic [IW-1:0] idx_q;
  logic [W-1:0]  merged_data;
  logic [KW-1:0] merged_k;

  always_ff @(posedge clk) begin
    if (!rst_n)                      idx_q <= '0;
    else if (idx_q == IW'(FW - 1))   idx_q <= '0;
    else                             idx_q <= idx_q + 1'b1;
  end

  assign echo_sel_o = echo_mask_i[region_of(int'(idx_q), FW)];

  // per byte lane selection between local and echoed word
  for (genvar l = 0; l < KW; l++) begin : g_lane
    assign merged_data[l*LW +: LW] = echo_sel_o ? echo_data_i[l*LW +: LW]
                                                : loc_data_i[l*LW +: LW];
    assign merged_k[l] = echo_sel_o ? echo_k_i[l] : loc_k_i[l];
  end

  // stitch register toward the transceiver; idle zeros while gated
  always_ff @(posedge clk) begin
    if (!rst_n || !tx_en_i) begin
      st_data_o <= '0;
      st_k_o    <= '0;
    end else begin
      st_data_o <= merged_data;
      st_k_o    <= merged_k;
    end
  end

endmodule

// File: rtl/llc_lock_det.sv
module llc_lock_det
  import llc_pkg::*;
#(
  parameter int FW     = 16,
  parameter int LOCK_N = 4,
  parameter int LOSS_N = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] low_byte_i,
  input  logic       k0_i,
  output logic       locked_o,
  output logic       hit_o,
  output logic       miss_o
);
  localparam int IW   = $clog2(FW);
  localparam int MAXN = (LOCK_N > LOSS_N) ? LOCK_N : LOSS_N;
  localparam int CW   = $clog2(MAXN + 1);

  logic [IW-1:0] pos_q;
  logic [CW-1:0] good_q, bad_q;
  logic          comma, at_start;

  assign comma    = is_comma(low_byte_i, k0_i);
  assign at_start = (pos_q == '0);
  assign hit_o    = comma && at_start;
  assign miss_o   = at_start && !comma;

  always_ff @(posedge clk) begin
    if (!rst_n)                          pos_q <= '0;
    else if (!locked_o && comma && !at_start) pos_q <= IW'(1);
    else if (pos_q == IW'(FW - 1))       pos_q <= '0;
    else                                 pos_q <= pos_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked_o <= 1'b0;
      good_q   <= '0;
      bad_q    <= '0;
    end else if (!locked_o) begin
      if (comma && at_start) begin
        if (good_q == CW'(LOCK_N - 1)) begin
          locked_o <= 1'b1;
          good_q   <= '0;
          bad_q    <= '0;
        end else begin
          good_q <= good_q + 1'b1;
        end
      end else if (comma) begin
        good_q <= CW'(1);
      end else if (at_start) begin
        good_q <= '0;
      end
    end else begin
      if (hit_o) begin
        bad_q <= '0;
      end else if (miss_o) begin
        if (bad_q == CW'(LOSS_N - 1)) begin
          locked_o <= 1'b0;
          bad_q    <= '0;
          good_q   <= '0;
        end else begin
          bad_q <= bad_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/llc_rx_path.sv
module llc_rx_path
  import llc_pkg::*;
#(
  parameter int W  = 32,
  parameter int KW = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          fwd_i,
  input  logic [N_REGION-1:0] echo_mask_i,
  input  logic [W-1:0]        xcv_data_i,
  input  logic [KW-1:0]       xcv_k_i,
  input  logic [W-1:0]        st_data_i,
  input  logic [KW-1:0]       st_k_i,
  input  logic [W-1:0]        loc_data_i,
  input  logic [KW-1:0]       loc_k_i,
  output logic [W-1:0]        sel_data_o,
  output logic [KW-1:0]       sel_k_o,
  output logic [W-1:0]        rx_data_o,
  output logic [KW-1:0]       rx_k_o,
  output logic                rx_valid_o,
  output logic                cfg_chg_o
);
  lb_mode_e            mode;
  logic [1:0]          fwd_q;
  logic [N_REGION-1:0] echo_q;

  assign mode = lb_mode_e'(fwd_i);

  always_comb begin
    case (mode)
      LB_PAR_STITCH: begin sel_data_o = st_data_i;  sel_k_o = st_k_i;  end
      LB_PAR_DIRECT: begin sel_data_o = loc_data_i; sel_k_o = loc_k_i; end
      default:       begin sel_data_o = xcv_data_i; sel_k_o = xcv_k_i; end
    endcase
  end

  assign cfg_chg_o = (fwd_i != fwd_q) || (echo_mask_i != echo_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwd_q      <= fwd_i;
      echo_q     <= echo_mask_i;
      rx_data_o  <= '0;
      rx_k_o     <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      fwd_q      <= fwd_i;
      echo_q     <= echo_mask_i;
      rx_data_o  <= sel_data_o;
      rx_k_o     <= sel_k_o;
      rx_valid_o <= !cfg_chg_o;
    end
  end

endmodule

// File: rtl/link_loop_ctrl.sv
module link_loop_ctrl
  import llc_pkg::*;
#(
  parameter int W      = 32,
  parameter int KW     = 4,
  parameter int FW     = 16,
  parameter int LOCK_N = 4,
  parameter int LOSS_N = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                is_master_i,
  input  logic                tx_force_i,
  input  logic [1:0]          lb_fwd_i,
  input  logic [N_REGION-1:0] lb_echo_i,
  input  logic [W-1:0]        fr_tx_data_i,
  input  logic [KW-1:0]       fr_tx_k_i,
  input  logic [W-1:0]        xcv_rx_data_i,
  input  logic [KW-1:0]       xcv_rx_k_i,
  output logic [W-1:0]        xcv_tx_data_o,
  output logic [KW-1:0]       xcv_tx_k_o,
  output logic                xcv_loop_o,
  output logic [W-1:0]        fr_rx_data_o,
  output logic [KW-1:0]       fr_rx_k_o,
  output logic                fr_rx_valid_o,
  output logic                rx_locked_o,
  output logic                tx_enable_o
);
  // named internal events for the checker
  logic          echo_sel;
  logic          lock_hit;
  logic          lock_miss;
  logic          cfg_chg;
  logic [W-1:0]  sel_data;
  logic [KW-1:0] sel_k;

  assign tx_enable_o = is_master_i || tx_force_i || rx_locked_o;
  assign xcv_loop_o  = (lb_mode_e'(lb_fwd_i) == LB_SERIAL);

  llc_tx_path #(.W(W), .KW(KW), .FW(FW)) u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .loc_data_i  (fr_tx_data_i),
    .loc_k_i     (fr_tx_k_i),
    .echo_data_i (xcv_rx_data_i),
    .echo_k_i    (xcv_rx_k_i),
    .echo_mask_i (lb_echo_i),
    .tx_en_i     (tx_enable_o),
    .st_data_o   (xcv_tx_data_o),
    .st_k_o      (xcv_tx_k_o),
    .echo_sel_o  (echo_sel)
  );

  llc_rx_path #(.W(W), .KW(KW)) u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .fwd_i       (lb_fwd_i),
    .echo_mask_i (lb_echo_i),
    .xcv_data_i  (xcv_rx_data_i),
    .xcv_k_i     (xcv_rx_k_i),
    .st_data_i   (xcv_tx_data_o),
    .st_k_i      (xcv_tx_k_o),
    .loc_data_i  (fr_tx_data_i),
    .loc_k_i     (fr_tx_k_i),
    .sel_data_o  (sel_data),
    .sel_k_o     (sel_k),
    .rx_data_o   (fr_rx_data_o),
    .rx_k_o      (fr_rx_k_o),
    .rx_valid_o  (fr_rx_valid_o),
    .cfg_chg_o   (cfg_chg)
  );

  llc_lock_det #(.FW(FW), .LOCK_N(LOCK_N), .LOSS_N(LOSS_N)) u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .low_byte_i (sel_data[7:0]),
    .k0_i       (sel_k[0]),
    .locked_o   (rx_locked_o),
    .hit_o      (lock_hit),
    .miss_o     (lock_miss)
  );

endmodule

// File: rtl/link_loop_ctrl_chk.sv
module link_loop_ctrl_chk #(
  parameter int W  = 32,
  parameter int KW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    lb_fwd_i,
  input logic [3:0]    lb_echo_i,
  input logic [W-1:0]  fr_tx_data_i,
  input logic [W-1:0]  xcv_rx_data_i,
  input logic [W-1:0]  xcv_tx_data_o,
  input logic [KW-1:0] xcv_tx_k_o,
  input logic [W-1:0]  fr_rx_data_o,
  input logic          fr_rx_valid_o,
  input logic          rx_locked_o,
  input logic          tx_enable_o,
  input logic          lock_hit,
  input logic          lock_miss
);

  assert_norm_path_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_fwd_i == 2'b00 || lb_fwd_i == 2'b01) |=> fr_rx_data_o == $past(xcv_rx_data_i));

  assert_direct_loop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_fwd_i == 2'b11) |=> fr_rx_data_o == $past(fr_tx_data_i));

  assert_stitch_loop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_fwd_i == 2'b10) |=> fr_rx_data_o == $past(xcv_tx_data_o));

  assert_cfg_dip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_fwd_i != $past(lb_fwd_i) || lb_echo_i != $past(lb_echo_i)) |=> !fr_rx_valid_o);

  assert_tx_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_enable_o |=> (xcv_tx_data_o == '0 && xcv_tx_k_o == '0));

  assert_lock_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_locked_o) |-> $past(lock_hit));

  assert_lock_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_locked_o) |-> $past(lock_miss));

endmodule

bind link_loop_ctrl link_loop_ctrl_chk #(.W(W), .KW(KW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .lb_fwd_i      (lb_fwd_i),
  .lb_echo_i     (lb_echo_i),
  .fr_tx_data_i  (fr_tx_data_i),
  .xcv_rx_data_i (xcv_rx_data_i),
  .xcv_tx_data_o (xcv_tx_data_o),
  .xcv_tx_k_o    (xcv_tx_k_o),
  .fr_rx_data_o  (fr_rx_data_o),
  .fr_rx_valid_o (fr_rx_valid_o),
  .rx_locked_o   (rx_locked_o),
  .tx_enable_o   (tx_enable_o),
  .lock_hit      (lock_hit),
  .lock_miss     (lock_miss)
);

// File: tb/link_loop_ctrl_tb.sv
module link_loop_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        is_master_i, tx_force_i;
  logic [1:0]  lb_fwd_i;
  logic [3:0]  lb_echo_i;
  logic [31:0] fr_tx_data_i, xcv_rx_data_i;
  logic [3:0]  fr_tx_k_i, xcv_rx_k_i;
  logic [31:0] xcv_tx_data_o, fr_rx_data_o;
  logic [3:0]  xcv_tx_k_o, fr_rx_k_o;
  logic        xcv_loop_o, fr_rx_valid_o, rx_locked_o, tx_enable_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int widx = 0;

  always #10 clk = ~clk;

  link_loop_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .is_master_i(is_master_i), .tx_force_i(tx_force_i),
    .lb_fwd_i(lb_fwd_i), .lb_echo_i(lb_echo_i),
    .fr_tx_data_i(fr_tx_data_i), .fr_tx_k_i(fr_tx_k_i),
    .xcv_rx_data_i(xcv_rx_data_i), .xcv_rx_k_i(xcv_rx_k_i),
    .xcv_tx_data_o(xcv_tx_data_o), .xcv_tx_k_o(xcv_tx_k_o), .xcv_loop_o(xcv_loop_o),
    .fr_rx_data_o(fr_rx_data_o), .fr_rx_k_o(fr_rx_k_o), .fr_rx_valid_o(fr_rx_valid_o),
    .rx_locked_o(rx_locked_o), .tx_enable_o(tx_enable_o)
  );

  // bench model of the transmit word index (R6)
  always @(posedge clk) begin
    if (!rst_n)          widx <= 0;
    else if (widx == 15) widx <= 0;
    else                 widx <= widx + 1;
  end

  typedef struct packed {
    logic [1:0]  fwd;
    logic [31:0] txd;
    logic [31:0] rxd;
    logic [31:0] exp_rx;
    logic        exp_v;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    '{2'b00, 32'h1111_1111, 32'hAAAA_0001, 32'hAAAA_0001, 1'b1},
    '{2'b00, 32'h2222_2222, 32'hAAAA_0002, 32'hAAAA_0002, 1'b1},
    '{2'b01, 32'h3333_3333, 32'hAAAA_0003, 32'hAAAA_0003, 1'b0},
    '{2'b01, 32'h4444_4444, 32'hAAAA_0004, 32'hAAAA_0004, 1'b1},
    '{2'b11, 32'h5555_5555, 32'hAAAA_0005, 32'h5555_5555, 1'b0},
    '{2'b11, 32'h6666_6666, 32'hAAAA_0006, 32'h6666_6666, 1'b1},
    '{2'b10, 32'h7777_7777, 32'hAAAA_0007, 32'h6666_6666, 1'b0},
    '{2'b10, 32'h8888_8888, 32'hAAAA_0008, 32'h7777_7777, 1'b1},
    '{2'b10, 32'h9999_9999, 32'hAAAA_0009, 32'h8888_8888, 1'b1},
    '{2'b00, 32'hABAB_ABAB, 32'hAAAA_000A, 32'hAAAA_000A, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send(input logic [31:0] d, input logic [3:0] k);
    xcv_rx_data_i = d;
    xcv_rx_k_i    = k;
    step();
  endtask

  task automatic comma();
    send(32'h0000_00BC, 4'b0001);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) send(32'h0000_0011, 4'b0000);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic string mode_tag(input logic [1:0] f);
    case (f)
      2'b00:   return "R1";
      2'b01:   return "R2";
      2'b11:   return "R3";
      default: return "R4";
    endcase
  endfunction

  // bench's own region map (R6)
  function automatic int region(input int w);
    if (w == 0)     return 0;
    else if (w < 4) return 1;
    else if (w < 8) return 2;
    return 3;
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] exp_tx, prev_tx;
    logic [3:0]  exp_k, prev_k;
    rst_n = 1'b0;
    is_master_i = 0; tx_force_i = 0; lb_fwd_i = 0; lb_echo_i = 0;
    fr_tx_data_i = 0; fr_tx_k_i = 0; xcv_rx_data_i = 0; xcv_rx_k_i = 0;
    repeat (3) @(negedge clk);

    // R11 reset state
    check("R11 rx_valid", {31'b0, fr_rx_valid_o}, 32'h0);
    check("R11 locked", {31'b0, rx_locked_o}, 32'h0);
    check("R11 tx_data", xcv_tx_data_o, 32'h0);
    check("R11 rx_data", fr_rx_data_o, 32'h0);
    check("R8 slave no lock", {31'b0, tx_enable_o}, 32'h0);
    rst_n = 1'b1;

    // vector table, master mode, no echo
    is_master_i = 1;
    for (int v = 0; v < NV; v++) begin
      lb_fwd_i      = TBL[v].fwd;
      fr_tx_data_i  = TBL[v].txd;
      xcv_rx_data_i = TBL[v].rxd;
      step();
      check(mode_tag(TBL[v].fwd), fr_rx_data_o, TBL[v].exp_rx);
      check("R5 tx word", xcv_tx_data_o, TBL[v].txd);
      check("R7 valid", {31'b0, fr_rx_valid_o}, {31'b0, TBL[v].exp_v});
      check("R2 serial loop flag", {31'b0, xcv_loop_o}, {31'b0, TBL[v].fwd == 2'b01});
    end

    // R7: echo mask change alone
    lb_echo_i = 4'b0001;
    step();
    check("R7 echo change dip", {31'b0, fr_rx_valid_o}, 32'h0);
    step();
    check("R7 valid restored", {31'b0, fr_rx_valid_o}, 32'h1);

    // R6 with R4: partial echo and stitched loop together
    lb_echo_i = 4'b0101;
    lb_fwd_i  = 2'b10;
    prev_tx = 0; prev_k = 0;
    for (int i = 0; i < 20; i++) begin
      int w;
      fr_tx_data_i  = 32'hA000_0000 | i;
      fr_tx_k_i     = 4'b0000;
      xcv_rx_data_i = 32'h5000_0000 | i;
      xcv_rx_k_i    = 4'b0010;
      w = widx;
      if (lb_echo_i[region(w)]) begin exp_tx = xcv_rx_data_i; exp_k = xcv_rx_k_i; end
      else                      begin exp_tx = fr_tx_data_i;  exp_k = fr_tx_k_i;  end
      step();
      check("R6 echo merge", xcv_tx_data_o, exp_tx);
      check("R6 echo k", {28'b0, xcv_tx_k_o}, {28'b0, exp_k});
      if (i > 0) begin
        check("R4 merged loop data", fr_rx_data_o, prev_tx);
        check("R4 merged loop k", {28'b0, fr_rx_k_o}, {28'b0, prev_k});
      end
      prev_tx = exp_tx;
      prev_k  = exp_k;
    end

    // slave gating and overrides
    lb_echo_i = 0; lb_fwd_i = 0; is_master_i = 0; tx_force_i = 0;
    xcv_rx_data_i = 0; xcv_rx_k_i = 0;
    do_reset();
    fr_tx_data_i = 32'hDEAD_BEEF; fr_tx_k_i = 4'hF;
    step();
    check("R8 gated enable", {31'b0, tx_enable_o}, 32'h0);
    check("R8 gated data", xcv_tx_data_o, 32'h0);
    check("R8 gated k", {28'b0, xcv_tx_k_o}, 32'h0);
    tx_force_i = 1;
    step();
    check("R12 force enable", {31'b0, tx_enable_o}, 32'h1);
    check("R12 force data", xcv_tx_data_o, 32'hDEAD_BEEF);
    tx_force_i = 0;
    step();
    check("R8 regated data", xcv_tx_data_o, 32'h0);
    is_master_i = 1;
    step();
    check("R12 master enable", {31'b0, tx_enable_o}, 32'h1);
    check("R12 master data", xcv_tx_data_o, 32'hDEAD_BEEF);
    is_master_i = 0;
    fr_tx_data_i = 0; fr_tx_k_i = 0;

    // R9 lock acquisition with a misaligned comma
    comma(); idle(15);
    comma(); idle(6);
    comma();               // misaligned: restarts count at one
    idle(15); comma(); idle(15); comma(); idle(15);
    check("R9 not yet locked", {31'b0, rx_locked_o}, 32'h0);
    check("R8 still gated", {31'b0, tx_enable_o}, 32'h0);
    comma();
    check("R9 locked", {31'b0, rx_locked_o}, 32'h1);
    check("R8 enabled by lock", {31'b0, tx_enable_o}, 32'h1);

    // R10 loss, with a miss-count clear
    idle(31); comma();
    idle(48);
    check("R10 three misses", {31'b0, rx_locked_o}, 32'h1);
    idle(15);
    check("R10 before fourth", {31'b0, rx_locked_o}, 32'h1);
    idle(1);
    check("R10 lock lost", {31'b0, rx_locked_o}, 32'h0);
    check("R8 disabled after loss", {31'b0, tx_enable_o}, 32'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule